// File: doc/BRIEF.md
# Lockable Multi-Mode Watchdog Timer

This block supervises software by counting down a programmable period on a slow tick input. Software chooses one of four reactions to an expiry and a period of 2^n ticks. It then sets the enable bit. From that point on, the enable, reaction and period fields are frozen until a power-on reset. Software keeps the timer from expiring by writing 1 to a kick bit. Every expiry sets a sticky status bit. Depending on the reaction, the expiry may also raise an interrupt level, a fixed-length reset request pulse, or both in sequence.

In the two-stage reaction, the first expiry raises the interrupt and reloads the timer with the same period. A second expiry with no kick in between requests a reset. The system reset that the block requests is fed back on a separate input. That input restarts the countdown, but the status bit and the frozen settings survive it. Only the power-on reset returns the block to its idle state. With the default tick of 125 ms, the selectable periods run from 125 ms to 4096 s.

Top module: `lwd_top`

## Requirements
- R1: After power-on reset the read word is all zero, and `irq_o` and `rst_req_o` are low.
- R2: While disabled, a write stores enable (bit 0), reaction (bits 2:1) and period select (bits 6:3), and all three read back at the same positions.
- R3: Once enable reads 1, writes cannot change enable, reaction or period select until power-on reset.
- R4: An expiry occurs on the 2^sel-th cycle with `tick_i` high after enabling or reloading, and it sets the status bit (bit 8).
- R5: Writing 1 to bit 7 while enabled reloads the countdown. A kick in the same cycle as an expiring tick prevents that expiry. Writing 0 there does nothing, and bit 7 always reads 0.
- R6: Writing 1 to bit 8 clears the status bit and writing 0 leaves it alone. An expiry in the same cycle as the clear wins, so the bit stays set.
- R7: With reaction 00 (flag only), an expiry sets only the status bit: no interrupt and no reset request.
- R8: With reaction 01 (reset), an expiry drives `rst_req_o` high for exactly PULSE_CLKS clocks, starting one clock after the expiring tick.
- R9: With reaction 10 (interrupt) or 11 (two-stage), `irq_o` equals the status bit and stays high until software clears it.
- R10: With reaction 11, the first expiry raises the interrupt and reloads without a reset request. An expiry while already in the second stage requests a PULSE_CLKS-clock reset.
- R11: A kick with reaction 11 returns the block to the first stage, so the next expiry is again treated as a first expiry.
- R12: A low `sys_rst_n` reloads the countdown and clears the stage. Enable, reaction, period select and the status bit are kept.
- R13: Power-on reset clears the lock and the status bit, so the configuration becomes writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst_n | input | 1 | Synchronous system reset, active low; restarts countdown and stage only |
| tick_i | input | 1 | One-clock time-base enable (one period unit) |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Register read value |
| irq_o | output | 1 | Interrupt request level |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
A corrupted countdown shows up at the ports as a status bit that sets one or more ticks early or late. The bench observes this within the first period after enabling. A stage register stuck in the wrong state shows up in the two-stage reaction: a reset pulse appears after the first expiry, or none appears after the second. Either error is visible within PULSE_CLKS+1 clocks of the expiring tick. A broken lock or a broken sticky bit changes the read word on the very next cycle after the offending write.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
   typedef enum logic [1:0] {
      WD_FLAG  = 2'b00,
      WD_RESET = 2'b01,
      WD_IRQ   = 2'b10,
      WD_TWO   = 2'b11
   } wd_mode_e;
endpackage

// File: rtl/lwd_regs.sv
module lwd_regs
   import lwd_pkg::*;
#(
   parameter int SEL_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic              en_o,
   output wd_mode_e          mode_o,
   output logic [SEL_W-1:0]  sel_nx_o,
   output logic              wte_o,
   output logic              kick_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int P_EN   = 0;
   localparam int P_MODE = 1;
   localparam int P_SEL  = 3;
   localparam int P_KICK = P_SEL + SEL_W;
   localparam int P_STAT = P_KICK + 1;

   logic             en_q;
   wd_mode_e         mode_q;
   logic [SEL_W-1:0] sel_q;
   logic             wte_q;
   logic             cfg_wr;

   // configuration is writable only while the timer is not yet enabled
   assign cfg_wr   = wr_en_i & ~en_q;
   assign sel_nx_o = cfg_wr ? wdata_i[P_SEL +: SEL_W] : sel_q;
   assign kick_o   = wr_en_i & en_q & wdata_i[P_KICK];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q   <= 1'b0;
         mode_q <= WD_FLAG;
         sel_q  <= '0;
         wte_q  <= 1'b0;
      end else begin
         if (cfg_wr) begin
            en_q   <= wdata_i[P_EN];
            mode_q <= wd_mode_e'(wdata_i[P_MODE +: 2]);
            sel_q  <= sel_nx_o;
         end
         // a new expiry outranks a clear in the same cycle
         if (expire_i)
            wte_q <= 1'b1;
         else if (wr_en_i && wdata_i[P_STAT])
            wte_q <= 1'b0;
      end
   end

   assign en_o   = en_q;
   assign mode_o = mode_q;
   assign wte_o  = wte_q;

   always_comb begin
      rdata_o                   = '0;
      rdata_o[P_EN]             = en_q;
      rdata_o[P_MODE +: 2]      = mode_q;
      rdata_o[P_SEL +: SEL_W]   = sel_q;
      rdata_o[P_STAT]           = wte_q;
   end
endmodule

// File: rtl/lwd_count.sv
module lwd_count #(
   parameter int SEL_W = 4,
   parameter int CNT_W = 2 ** SEL_W
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period;

   assign period   = CNT_W'(1) << sel_i;
   assign expire_o = run_i & sys_rst_n & tick_i & ~kick_i & (cnt_q == CNT_W'(1));

   // held at the full period while disabled, so enabling starts a fresh count
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt_q <= CNT_W'(1);
      else if (!run_i || !sys_rst_n || kick_i || expire_o)
         cnt_q <= period;
      else if (tick_i)
         cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/lwd_action.sv
module lwd_action
   import lwd_pkg::*;
#(
   parameter int PULSE_CLKS = 4
) (
   input  logic     clk,
   input  logic     por_n,
   input  logic     sys_rst_n,
   input  logic     expire_i,
   input  logic     kick_i,
   input  wd_mode_e mode_i,
   input  logic     wte_i,
   output logic     stage_o,
   output logic     irq_o,
   output logic     rst_req_o
);
   logic second_q;
   logic fire;
   logic [1:0] mode_bits;

   assign mode_bits = mode_i;
   assign fire = expire_i & ((mode_i == WD_RESET) | ((mode_i == WD_TWO) & second_q));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         second_q <= 1'b0;
      else if (!sys_rst_n || kick_i)
         second_q <= 1'b0;
      else if (expire_i && mode_i == WD_TWO)
         second_q <= 1'b1;
   end

   assign stage_o = second_q;
   assign irq_o   = wte_i & mode_bits[1];

   generate
      if (PULSE_CLKS == 1) begin : g_single
         logic pulse_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) pulse_q <= 1'b0;
            else        pulse_q <= fire;
         end
         assign rst_req_o = pulse_q;
      end else begin : g_multi
         localparam int PW = $clog2(PULSE_CLKS + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               left_q <= '0;
            else if (fire)
               left_q <= PW'(PULSE_CLKS);
            else if (left_q != '0)
               left_q <= left_q - PW'(1);
         end
         assign rst_req_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/lwd_top.sv
module lwd_top
   import lwd_pkg::*;
#(
   parameter int SEL_W      = 4,
   parameter int DATA_W     = 16,
   parameter int PULSE_CLKS = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   localparam int CNT_W = 2 ** SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
         $error("lwd_top: SEL_W must be 1..5");
      end
      if (DATA_W < SEL_W + 5) begin : g_bad_data
         $error("lwd_top: DATA_W too narrow for register layout");
      end
      if (PULSE_CLKS < 1) begin : g_bad_pulse
         $error("lwd_top: PULSE_CLKS must be at least 1");
      end
   endgenerate

   logic             en;
   wd_mode_e         mode;
   logic [SEL_W-1:0] sel_nx;
   logic             wte;
   logic             kick;
   logic             expire;
   logic             stage;

   lwd_regs #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .por_n(por_n), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
      .expire_i(expire), .en_o(en), .mode_o(mode), .sel_nx_o(sel_nx),
      .wte_o(wte), .kick_o(kick), .rdata_o(rdata_o)
   );

   lwd_count #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_count (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .run_i(en),
      .tick_i(tick_i), .kick_i(kick), .sel_i(sel_nx), .expire_o(expire)
   );

   lwd_action #(.PULSE_CLKS(PULSE_CLKS)) u_act (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .expire_i(expire),
      .kick_i(kick), .mode_i(mode), .wte_i(wte), .stage_o(stage),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );
endmodule

// File: rtl/lwd_check.sv
module lwd_check #(
   parameter int SEL_W  = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              por_n,
   input logic              tick_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              rst_req_o,
   input logic              expire,
   input logic              stage
);
   localparam int ST = SEL_W + 4;

   // R3: enable cannot drop once set
   a_r3_en_held: assert property (@(posedge clk) disable iff (!por_n)
      rdata_o[0] |=> rdata_o[0]);

   // R3: reaction and period select frozen while enabled
   a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
      rdata_o[0] |=> $stable(rdata_o[SEL_W+2:1]));

   // R6: status stays set unless a clear is written
   a_r6_wte_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (rdata_o[ST] && !(wr_en_i && wdata_i[ST])) |=> rdata_o[ST]);

   // R4: expiry only on a tick while enabled
   a_r4_expire_gated: assert property (@(posedge clk) disable iff (!por_n)
      expire |-> (tick_i && rdata_o[0]));

   // R7: flag-only reaction never starts a reset request
   a_r7_flag_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (rdata_o[0] && rdata_o[2:1] == 2'b00 && !rst_req_o) |=> !rst_req_o);

   // R8: a reset request starts only after an expiry
   a_r8_rst_cause: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req_o) |-> $past(expire));

   // R10: first two-stage expiry arms the second stage
   a_r10_arm: assert property (@(posedge clk) disable iff (!por_n)
      (expire && rdata_o[2:1] == 2'b11 && !stage) |=> stage);
endmodule

bind lwd_top lwd_check #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .por_n(por_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
   .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o),
   .expire(expire), .stage(stage)
);

// File: tb/test_lwd_top.sv
`timescale 1ns/1ps
module test_lwd_top;
   localparam int DW = 16;
   localparam int PC = 4;
   localparam logic [DW-1:0] KICK = 16'h0080;
   localparam logic [DW-1:0] CLR  = 16'h0100;

   logic clk = 1'b0;
   logic por_n = 1'b0, sys_rst_n = 1'b1, tick = 1'b0, wr_en = 1'b0;
   logic [DW-1:0] wdata = '0, rdata;
   logic irq, rst_req;
   int n_chk = 0, n_fail = 0, rst_seen = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lwd_top #(.SEL_W(4), .DATA_W(DW), .PULSE_CLKS(PC)) i_lwd_top (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_i(tick),
      .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
      .rst_req_o(rst_req)
   );

   always @(negedge clk) if (rst_req) rst_seen++;

   // mode[16:15] sel[14:11] ticks[10:6] wte[5] irq[4] rst_clks[3:0]
   localparam logic [16:0] VECS [0:7] = '{
      {2'd0, 4'd1, 5'd1, 1'b0, 1'b0, 4'd0},
      {2'd0, 4'd1, 5'd2, 1'b1, 1'b0, 4'd0},
      {2'd1, 4'd0, 5'd1, 1'b1, 1'b0, 4'd4},
      {2'd2, 4'd2, 5'd3, 1'b0, 1'b0, 4'd0},
      {2'd2, 4'd2, 5'd4, 1'b1, 1'b1, 4'd0},
      {2'd3, 4'd1, 5'd2, 1'b1, 1'b1, 4'd0},
      {2'd3, 4'd1, 5'd4, 1'b1, 1'b1, 4'd4},
      {2'd1, 4'd3, 5'd7, 1'b0, 1'b0, 4'd0}
   };

   function automatic logic [DW-1:0] cfgw(int mode, int sel, int en);
      return DW'(en) | (DW'(mode) << 1) | (DW'(sel) << 3);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [DW-1:0] d);
      @(negedge clk); wr_en = 1'b1; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic por();
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1; rst_seen = 0;
   endtask

   task automatic sysrst();
      @(negedge clk); sys_rst_n = 1'b0;
      cyc(2); sys_rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(2);
      chk("R1 rdata after por", 32'(rdata), 0);
      chk("R1 irq after por", 32'(irq), 0);
      chk("R1 rst_req after por", 32'(rst_req), 0);
      por_n = 1'b1;
      cyc(1);

      // table-driven reactions
      for (int v = 0; v < 8; v++) begin
         logic [16:0] e;
         e = VECS[v];
         por();
         wr(cfgw(int'(e[16:15]), int'(e[14:11]), 1));
         chk("R2 config readback", 32'(rdata), 32'(cfgw(int'(e[16:15]), int'(e[14:11]), 1)));
         ticks(int'(e[10:6]));
         cyc(PC + 2);
         chk("R4/R7/R9 status bit", 32'(rdata[8]), 32'(e[5]));
         chk("R9/R10 irq level", 32'(irq), 32'(e[4]));
         chk("R8/R10 reset pulse clocks", 32'(rst_seen), 32'(e[3:0]));
      end

      // R2 unlocked write reads back, R3 lock, R13 por unlocks
      por();
      wr(cfgw(1, 3, 0));
      chk("R2 disabled write readback", 32'(rdata), 32'(cfgw(1, 3, 0)));
      wr(cfgw(2, 2, 1));
      wr(cfgw(0, 5, 0));
      chk("R3 locked config unchanged", 32'(rdata), 32'(cfgw(2, 2, 1)));
      por();
      chk("R13 por clears lock", 32'(rdata), 0);
      wr(cfgw(1, 6, 0));
      chk("R13 writable after por", 32'(rdata), 32'(cfgw(1, 6, 0)));

      // R5 kick reloads, reads 0, write 0 ignored
      por();
      wr(cfgw(0, 1, 1));
      ticks(1);
      wr(KICK);
      chk("R5 kick bit reads 0", 32'(rdata[7]), 0);
      ticks(1);
      chk("R5 kick reloaded count", 32'(rdata[8]), 0);
      wr('0);
      ticks(1);
      chk("R5 write 0 no reload", 32'(rdata[8]), 1);

      // R6 clear and write-0
      wr('0);
      chk("R6 write 0 keeps status", 32'(rdata[8]), 1);
      wr(CLR);
      chk("R6 write 1 clears status", 32'(rdata[8]), 0);

      // R6 set wins over clear, R5 kick beats expiry
      por();
      wr(cfgw(0, 0, 1));
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; wdata = CLR;
      @(negedge clk); tick = 1'b0; wr_en = 1'b0; wdata = '0;
      chk("R6 expiry beats clear", 32'(rdata[8]), 1);
      wr(CLR);
      @(negedge clk); tick = 1'b1; wr_en = 1'b1; wdata = KICK;
      @(negedge clk); tick = 1'b0; wr_en = 1'b0; wdata = '0;
      chk("R5 kick blocks same-cycle expiry", 32'(rdata[8]), 0);
      ticks(1);
      chk("R4 period 1 expires on next tick", 32'(rdata[8]), 1);

      // R9 irq follows status until cleared
      por();
      wr(cfgw(2, 0, 1));
      ticks(1);
      chk("R9 irq raised", 32'(irq), 1);
      cyc(3);
      chk("R9 irq held", 32'(irq), 1);
      wr(CLR);
      chk("R9 irq drops on clear", 32'(irq), 0);

      // R11 kick returns two-stage to first stage
      por();
      wr(cfgw(3, 0, 1));
      ticks(1);
      cyc(PC + 2);
      chk("R10 first expiry irq", 32'(irq), 1);
      chk("R10 first expiry no reset", 32'(rst_seen), 0);
      wr(KICK);
      ticks(1);
      cyc(PC + 2);
      chk("R11 after kick expiry is first", 32'(rst_seen), 0);
      ticks(1);
      cyc(PC + 2);
      chk("R10 second expiry resets", 32'(rst_seen), PC);

      // R12 system reset keeps settings and status
      por();
      wr(cfgw(1, 0, 1));
      ticks(1);
      cyc(PC + 2);
      chk("R8 reset pulse length", 32'(rst_seen), PC);
      sysrst();
      chk("R12 settings and status survive", 32'(rdata), 32'(cfgw(1, 0, 1) | CLR));
      por();
      wr(cfgw(0, 1, 1));
      ticks(1);
      sysrst();
      ticks(1);
      chk("R12 countdown restarted", 32'(rdata[8]), 0);
      ticks(1);
      chk("R12 full period after restart", 32'(rdata[8]), 1);
      por();
      wr(cfgw(3, 0, 1));
      ticks(1);
      sysrst();
      ticks(1);
      cyc(PC + 2);
      chk("R12 stage cleared", 32'(rst_seen), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule